// File: doc/BRIEF.md
# Serial Configuration Write Receiver

This block receives register writes from a host over a three-wire serial link: a data line, a serial clock and an active-low load strobe. While the strobe is low, bits are taken on rising serial-clock edges, least significant bit first. The first eight bits form a register address. Every group of six bits after that is one data word. A complete word is written to the current address, and the address then steps up by one. A host can therefore fill a run of neighbouring registers while sending the start address only once.

All three serial pins pass through synchronizers into the system clock domain, so the serial clock must be several times slower than the system clock. Each completed word produces a single-cycle write toward a register bank, with address, data and a tag. The tag tells the bank whether the target register takes effect at once or waits for the next video-timing update. Bits that do not finish a word, such as two padding bits from a 16-bit host or a word cut off by the strobe, are discarded.

Top module: `serial_cfg_port`

## Requirements
- R1: Bits are taken only on rising serial-clock edges while the load strobe is low; clock edges while the strobe is high cause no write.
- R2: After the strobe falls, the first 8 bits are the address (bit 0 first) and the next 6 bits are the data (bit 0 first); the write carries exactly that address and data.
- R3: Each further complete 6-bit word in the same strobe-low burst is written to the previous word's address plus one.
- R4: Address advance wraps from 0xFF to 0x00.
- R5: A word left incomplete when the strobe rises, including two padding bits after a full word, issues no write.
- R6: While the strobe is high the bit count is cleared, so the next burst again begins with 8 address bits.
- R7: `wr_en` is high for exactly one system-clock cycle per completed word, SYNC_STAGES+1 system-clock rising edges after the system clock first samples the raw serial-clock rise.
- R8: `wr_imm` is 1 when the written address lies in the inclusive range IMM_LO..IMM_HI (defaults 0x10..0x1F) and 0 otherwise.
- R9: After reset, `wr_en`, `wr_addr`, `wr_data` and `wr_imm` are all 0.
- R10: A serial-clock rise that reaches the synchronized domain in the same system cycle as the strobe's rise is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data from the host |
| ser_ld_n | input | 1 | Active-low load strobe that frames a burst |
| wr_en | output | 1 | One-cycle write pulse per completed word |
| wr_addr | output | 8 | Target register address |
| wr_data | output | 6 | Data word |
| wr_imm | output | 1 | 1 for an immediate register, 0 for one that waits for a video-timing update |

## Verification
The delicate case is a serial-clock rise and the strobe's rise landing in the same synchronized cycle, where bit capture and frame reset meet. The bench provokes this by changing both pins at the same system-clock edge on what would be the last bit of a word. It expects the strobe to win, with no write. A reference model sees the same pins through its own delay queue and must agree on every clock. Word completion at address 0xFF, where a write and the address wrap happen together, is judged in the same way.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
   typedef enum logic {
      PH_ADDR = 1'b0,
      PH_DATA = 1'b1
   } cfgser_phase_e;

   function automatic int cfgser_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgser_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[i] <= RST_VAL;
            end else if (i == 0) begin
               chain[i] <= d_in;
            end else begin
               chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/cfgser_tag.sv
module cfgser_tag #(
   parameter int ADDR_W = 8,
   parameter int IMM_LO = 16,
   parameter int IMM_HI = 31
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              imm
);
   generate
      if (IMM_HI < IMM_LO) begin : g_none
         assign imm = 1'b0;
      end else if (IMM_LO == 0) begin : g_low_open
         assign imm = (addr <= ADDR_W'(IMM_HI));
      end else begin : g_window
         assign imm = (addr >= ADDR_W'(IMM_LO)) && (addr <= ADDR_W'(IMM_HI));
      end
   endgenerate
endmodule

// File: rtl/cfgser_deser.sv
module cfgser_deser
   import cfgser_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_s,
   input  logic              sck_s,
   input  logic              dat_s,
   input  logic              imm_in,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              sck_rise,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_imm
);
   localparam int CNT_W = $clog2(cfgser_max(ADDR_W, DATA_W) + 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

   cfgser_phase_e     phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [ADDR_W-1:0] addr_sh;
   logic [DATA_W-1:0] data_sh;
   logic              sck_d;

   assign sck_rise = sck_s & ~sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_ADDR;
         bit_cnt  <= '0;
         addr_sh  <= '0;
         data_sh  <= '0;
         cur_addr <= '0;
         sck_d    <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         wr_imm   <= 1'b0;
      end else begin
         sck_d <= sck_s;
         wr_en <= 1'b0;
         if (ld_s) begin
            phase   <= PH_ADDR;
            bit_cnt <= '0;
         end else if (sck_rise) begin
            unique case (phase)
               PH_ADDR: begin
                  addr_sh <= {dat_s, addr_sh[ADDR_W-1:1]};
                  if (bit_cnt == ADDR_LAST) begin
                     cur_addr <= {dat_s, addr_sh[ADDR_W-1:1]};
                     phase    <= PH_DATA;
                     bit_cnt  <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               PH_DATA: begin
                  data_sh <= {dat_s, data_sh[DATA_W-1:1]};
                  if (bit_cnt == DATA_LAST) begin
                     wr_en    <= 1'b1;
                     wr_addr  <= cur_addr;
                     wr_data  <= {dat_s, data_sh[DATA_W-1:1]};
                     wr_imm   <= imm_in;
                     cur_addr <= cur_addr + 1'b1;
                     bit_cnt  <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               default: begin
                  phase <= PH_ADDR;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int IMM_LO      = 16,
   parameter int IMM_HI      = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_ld_n,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_imm
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("serial_cfg_port: ADDR_W out of range 2..16");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("serial_cfg_port: DATA_W must be at least 2");
      end
      if (IMM_HI >= ADDR_SPAN) begin : g_bad_imm
         $error("serial_cfg_port: IMM_HI beyond address space");
      end
   endgenerate

   logic              sck_s, dat_s, ld_n_s, ld_s;
   logic              sck_rise, imm_cur;
   logic [ADDR_W-1:0] cur_addr;

   cfgser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d_in(ser_clk), .d_out(sck_s));
   cfgser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d_in(ser_dat), .d_out(dat_s));
   cfgser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
      .clk(clk), .rst_n(rst_n), .d_in(ser_ld_n), .d_out(ld_n_s));

   assign ld_s = ld_n_s;

   cfgser_tag #(.ADDR_W(ADDR_W), .IMM_LO(IMM_LO), .IMM_HI(IMM_HI)) u_tag (
      .addr(cur_addr), .imm(imm_cur));

   cfgser_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deser (
      .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .sck_s(sck_s), .dat_s(dat_s),
      .imm_in(imm_cur), .cur_addr(cur_addr), .sck_rise(sck_rise),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_imm(wr_imm));
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
   parameter int ADDR_W = 8,
   parameter int IMM_LO = 16,
   parameter int IMM_HI = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_s,
   input logic              sck_rise,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_imm
);
   logic              seen_wr;
   logic [ADDR_W-1:0] last_addr;
   logic              in_win;

   assign in_win = (int'(wr_addr) >= IMM_LO) && (int'(wr_addr) <= IMM_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_wr   <= 1'b0;
         last_addr <= '0;
      end else if (ld_s) begin
         seen_wr <= 1'b0;
      end else if (wr_en) begin
         seen_wr   <= 1'b1;
         last_addr <= wr_addr;
      end
   end

   AST_WR_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(sck_rise));                                    // R1
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && seen_wr) |-> (wr_addr == last_addr + 1'b1));         // R3
   AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      ld_s |=> !wr_en);                                              // R6
   AST_ONE_CYCLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);                                             // R7
   AST_TAG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_imm == in_win));                                 // R8
endmodule

bind serial_cfg_port serial_cfg_port_chk #(
   .ADDR_W(ADDR_W), .IMM_LO(IMM_LO), .IMM_HI(IMM_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .sck_rise(sck_rise),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_imm(wr_imm));

// File: tb/serial_cfg_port_test.sv
`timescale 1ns/1ps
module serial_cfg_port_test;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld_n = 1'b1;
   logic       wr_en, wr_imm;
   logic [7:0] wr_addr;
   logic [5:0] wr_data;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   serial_cfg_port uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_ld_n(ser_ld_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_imm(wr_imm));

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Behavioural reference model: pins seen through a delay queue.
   int q_sck[$], q_dat[$], q_ld[$];
   int m_prev_sck, m_cnt, m_in_addr, m_addr, m_ash, m_dsh;
   int e_we, e_addr, e_data, e_imm;

   function automatic int in_win(input int a);
      return (a >= 16 && a <= 31) ? 1 : 0;
   endfunction

   task automatic model_reset();
      q_sck = {}; q_dat = {}; q_ld = {};
      for (int i = 0; i < SYNC; i++) begin
         q_sck.push_front(0); q_dat.push_front(0); q_ld.push_front(1);
      end
      m_prev_sck = 0; m_cnt = 0; m_in_addr = 1; m_addr = 0; m_ash = 0; m_dsh = 0;
      e_we = 0; e_addr = 0; e_data = 0; e_imm = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         int s_sck, s_dat, s_ld;
         s_sck = q_sck.pop_back(); s_dat = q_dat.pop_back(); s_ld = q_ld.pop_back();
         e_we = 0;
         if (s_ld != 0) begin
            m_cnt = 0; m_in_addr = 1;
         end else if (s_sck == 1 && m_prev_sck == 0) begin
            if (m_in_addr != 0) begin
               m_ash = m_ash | (s_dat << m_cnt);
               m_cnt++;
               if (m_cnt == 8) begin
                  m_addr = m_ash; m_ash = 0; m_cnt = 0; m_in_addr = 0;
               end
            end else begin
               m_dsh = m_dsh | (s_dat << m_cnt);
               m_cnt++;
               if (m_cnt == 6) begin
                  e_we = 1; e_addr = m_addr; e_data = m_dsh; e_imm = in_win(m_addr);
                  m_addr = (m_addr + 1) % 256; m_dsh = 0; m_cnt = 0;
               end
            end
         end
         if (s_ld != 0) begin m_ash = 0; m_dsh = 0; end
         m_prev_sck = s_sck;
         q_sck.push_front(int'(ser_clk)); q_dat.push_front(int'(ser_dat));
         q_ld.push_front(int'(ser_ld_n));
      end
   end

   // Per-clock comparison, write capture and latency measurement.
   int pcyc = 0, rise_pc = 0, lat_last = -1;
   int g_addr[$], g_data[$], g_imm[$];

   always @(posedge clk) pcyc++;

   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 per-clock wr_en", int'(wr_en), e_we);
         check("R2 per-clock wr_addr", int'(wr_addr), e_addr);
         check("R2 per-clock wr_data", int'(wr_data), e_data);
         check("R8 per-clock wr_imm", int'(wr_imm), e_imm);
         if (wr_en) begin
            g_addr.push_back(int'(wr_addr)); g_data.push_back(int'(wr_data));
            g_imm.push_back(int'(wr_imm)); lat_last = pcyc - rise_pc;
         end
      end
   end

   task automatic clear_got();
      g_addr = {}; g_data = {}; g_imm = {};
   endtask

   task automatic send_bits(input int val, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ser_clk = 1'b0; ser_dat = val[i];
         repeat (3) @(negedge clk);
         ser_clk = 1'b1; rise_pc = pcyc;
         repeat (3) @(negedge clk);
      end
      @(negedge clk); ser_clk = 1'b0;
   endtask

   task automatic open_frame();
      clear_got();
      @(negedge clk); ser_ld_n = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic close_frame();
      repeat (4) @(negedge clk);
      ser_ld_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      check("R9 reset wr_en", int'(wr_en), 0);
      check("R9 reset wr_addr", int'(wr_addr), 0);
      check("R9 reset wr_data", int'(wr_data), 0);
      check("R9 reset wr_imm", int'(wr_imm), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 single frame, R7 latency and width, R8 outside window
      open_frame(); send_bits(8'h05, 8); send_bits(6'h2A, 6); close_frame();
      check("R2 single write count", g_addr.size(), 1);
      if (g_addr.size() == 1) begin
         check("R2 address", g_addr[0], 8'h05);
         check("R2 data", g_data[0], 6'h2A);
         check("R8 tag outside window", g_imm[0], 0);
      end
      check("R7 latency", lat_last, SYNC + 1);

      // R3 burst crossing the window's upper edge, R8 tags
      open_frame(); send_bits(8'h1E, 8);
      send_bits(6'h11, 6); send_bits(6'h22, 6); send_bits(6'h33, 6); close_frame();
      check("R3 burst count", g_addr.size(), 3);
      if (g_addr.size() == 3) begin
         check("R3 addr word1", g_addr[1], 8'h1F);
         check("R3 addr word2", g_addr[2], 8'h20);
         check("R3 data word2", g_data[2], 6'h33);
         check("R8 tag 0x1E", g_imm[0], 1);
         check("R8 tag 0x20", g_imm[2], 0);
      end

      // R4 wrap
      open_frame(); send_bits(8'hFE, 8);
      send_bits(6'h01, 6); send_bits(6'h3F, 6); send_bits(6'h15, 6); close_frame();
      check("R4 wrap count", g_addr.size(), 3);
      if (g_addr.size() == 3) begin
         check("R4 addr 0xFF", g_addr[1], 8'hFF);
         check("R4 addr wraps to 0", g_addr[2], 8'h00);
         check("R4 data after wrap", g_data[2], 6'h15);
      end

      // R5 two padding bits from a 16-bit host
      open_frame(); send_bits(8'h11, 8); send_bits(6'h15, 6); send_bits(2'b11, 2);
      close_frame();
      check("R5 padding ignored count", g_addr.size(), 1);

      // R5 partial word, then R6 fresh address phase
      open_frame(); send_bits(8'h30, 8); send_bits(6'h0C, 6); send_bits(3'b101, 3);
      close_frame();
      check("R5 partial word dropped", g_addr.size(), 1);
      open_frame(); send_bits(8'h31, 8); send_bits(6'h01, 6); close_frame();
      check("R6 new frame count", g_addr.size(), 1);
      if (g_addr.size() == 1) check("R6 new frame address", g_addr[0], 8'h31);

      // R1 clocking with strobe high
      clear_got(); send_bits(14'h2ABC, 14); repeat (10) @(negedge clk);
      check("R1 strobe high no write", g_addr.size(), 0);

      // R10 strobe rise together with the last bit's clock rise
      open_frame(); send_bits(8'h40, 8); send_bits(5'h1F, 5);
      @(negedge clk); ser_clk = 1'b0; ser_dat = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1; ser_ld_n = 1'b1;
      repeat (10) @(negedge clk); ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 coincident edge dropped", g_addr.size(), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule